// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

The block is a memory-mapped real-time clock. It keeps a 32-bit count of seconds and is reached through a plain strobe bus of 16-bit registers. A prescaler counts reference clock cycles. Each time the number of cycles held in a programmable 32-bit frequency word has elapsed, the prescaler advances the seconds count by one. Software normally writes the reference clock rate in Hz into the frequency word, so the count then moves once per second.

Software never reaches the running counter directly. To preset it, software writes a 32-bit preset value and raises a load request. To read it, software raises a snapshot request, which copies the counter into a pair of capture registers. Both requests are self-clearing bits that software polls until they read 0. A 32-bit match value sets a sticky alarm flag. That flag drives an interrupt output, which a mask bit can block, a force bit can assert, and a clear bit can acknowledge. A soft-reset bit in the control register restarts the time-keeping state and leaves the configuration in place.

Top module: `sec_rtc`

## Requirements
- R1: The register byte offsets are as follows. 0x00 is control. 0x04 and 0x08 hold the frequency word (bits 15:0, then bits 31:16). 0x0C and 0x10 hold the preset value, 0x14 and 0x18 the match value, in the same halves. 0x1C is status. 0x20 and 0x24 hold the captured count, low half then high half. The frequency, preset and match halves read back what was last written. Control bit 7 always reads 0. Any other address reads 0.
- R2: Control bit positions: bit0 run (0 holds the soft reset), bit1 count enable, bit2 wrap enable, bit3 load request, bit4 snapshot request, bit5 interrupt mask, bit6 interrupt force, bit7 interrupt clear. Writing 0 to bit3 or bit4 does not cancel a request already pending.
- R3: A control write with bit3 set makes bit3 read 1 after that write edge and after the next edge. At the second edge after the write, the counter takes the preset value and bit3 reads 0.
- R4: A control write with bit4 set makes bit4 read 1 for two cycles. It then reads 0, and the capture registers hold the counter value. If bit3 and bit4 are set in the same write, the capture holds the newly loaded preset value. Writes to 0x1C, 0x20 and 0x24 change nothing.
- R5: While counting is enabled, the counter advances once every F clock cycles, where F is the frequency word and a word of 0 acts as 1. From a cleared prescaler, the first advance comes on the F-th enabled edge.
- R6: While count enable is 0, the counter and the prescaler hold their values.
- R7: When the counter advances from 0xFFFFFFFF, it becomes 0 if wrap enable is 1. If wrap enable is 0, it stays at 0xFFFFFFFF.
- R8: The alarm flag sets when the counter is advanced or loaded to a value equal to the match value. The interrupt output is the raw interrupt with the mask (control bit5) applied.
- R9: Status bit0 is the raw interrupt, which is the alarm flag OR the force bit. Status bit1 is the interrupt output, which is high while bit0 is 1 and the mask is 0.
- R10: Writing control bit7 as 1 clears the alarm flag. If an alarm event falls on the same edge as the clear, the flag stays set.
- R11: While the run bit is 0, every clock clears the counter, the prescaler, the alarm flag and both requests. The frequency, preset, match and other control bits keep their values.
- R12: After the global reset, control reads 0x0001, the frequency word holds the FREQ_RST parameter (default 32768), all other registers read 0, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous global reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W (6) | Byte address of the register |
| wdata | input | REG_W (16) | Write data |
| rdata | output | REG_W (16) | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt output, high while pending and unmasked |

## Verification
Embedded properties check on every cycle that a request completes two edges after it is raised and that a load installs the preset value. They also check that a capture takes the counter value, that a disabled counter and prescaler hold still, and that saturation holds at the top value. Two further properties check that the alarm flag persists until a clear, and that a held soft reset empties all time-keeping state. Only the bench scenarios can show the prescaler's exact tick count for random frequency words and run lengths, including rollover near the top. The same holds for the same-write load-then-capture order, a clear that falls on a match edge, and the status and interrupt combinations across mask and force.

// File: rtl/sec_rtc.sv
`timescale 1ns/1ps
module sec_rtc #(
  parameter int REG_W = 16,
  parameter int ADDR_W = 6,
  parameter logic [2*REG_W-1:0] FREQ_RST = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * REG_W;
  localparam logic [ADDR_W-1:0] A_CTL = (ADDR_W)'(8'h00);
  localparam logic [ADDR_W-1:0] A_FQL = (ADDR_W)'(8'h04);
  localparam logic [ADDR_W-1:0] A_FQH = (ADDR_W)'(8'h08);
  localparam logic [ADDR_W-1:0] A_LDL = (ADDR_W)'(8'h0C);
  localparam logic [ADDR_W-1:0] A_LDH = (ADDR_W)'(8'h10);
  localparam logic [ADDR_W-1:0] A_MTL = (ADDR_W)'(8'h14);
  localparam logic [ADDR_W-1:0] A_MTH = (ADDR_W)'(8'h18);
  localparam logic [ADDR_W-1:0] A_STS = (ADDR_W)'(8'h1C);
  localparam logic [ADDR_W-1:0] A_CPL = (ADDR_W)'(8'h20);
  localparam logic [ADDR_W-1:0] A_CPH = (ADDR_W)'(8'h24);

  logic run_n, cnt_en, wrap_en, mask, force_q;
  logic ld_req, ld_stg, sn_req, sn_stg, pend;
  logic [CNT_W-1:0] freq, ld_val, match_val, snap, cnt_q, pre_q, nxt;
  logic upd, tick, hit, raw;

  wire wr_ctl = wr_en && (addr == A_CTL);
  wire clr_wr = wr_ctl && wdata[7];
  wire at_top = &cnt_q;
  wire [CNT_W:0] pre_inc = {1'b0, pre_q} + 1'b1;

  assign tick = cnt_en && (pre_inc >= {1'b0, freq});
  assign hit  = upd && (nxt == match_val);
  assign raw  = pend | force_q;
  assign irq  = raw & ~mask;

  always_comb begin
    upd = 1'b0;
    nxt = cnt_q;
    if (ld_stg) begin
      upd = 1'b1;
      nxt = ld_val;
    end else if (tick) begin
      if (!at_top) begin
        upd = 1'b1;
        nxt = cnt_q + 1'b1;
      end else if (wrap_en) begin
        upd = 1'b1;
        nxt = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {force_q, mask, wrap_en, cnt_en} <= '0;
      run_n     <= 1'b1;
      freq      <= FREQ_RST;
      ld_val    <= '0;
      match_val <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTL: {force_q, mask, wrap_en, cnt_en, run_n} <= {wdata[6:5], wdata[2:0]};
        A_FQL: freq[REG_W-1:0]          <= wdata;
        A_FQH: freq[CNT_W-1:REG_W]      <= wdata;
        A_LDL: ld_val[REG_W-1:0]        <= wdata;
        A_LDH: ld_val[CNT_W-1:REG_W]    <= wdata;
        A_MTL: match_val[REG_W-1:0]     <= wdata;
        A_MTH: match_val[CNT_W-1:REG_W] <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
      {pend, ld_req, ld_stg, sn_req, sn_stg} <= '0;
    end else if (!run_n) begin
      cnt_q <= '0;
      pre_q <= '0;
      {pend, ld_req, ld_stg, sn_req, sn_stg} <= '0;
    end else begin
      pre_q <= tick ? '0 : (cnt_en ? pre_q + 1'b1 : pre_q);
      if (upd) cnt_q <= nxt;
      if (hit) pend <= 1'b1;
      else if (clr_wr) pend <= 1'b0;
      ld_stg <= ld_req && !ld_stg;
      ld_req <= (ld_req && !ld_stg) || (wr_ctl && wdata[3]);
      sn_stg <= sn_req && !sn_stg;
      sn_req <= (sn_req && !sn_stg) || (wr_ctl && wdata[4]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap <= '0;
    else if (run_n && sn_stg) snap <= ld_stg ? ld_val : cnt_q;
  end

  always_comb begin
    case (addr)
      A_CTL: rdata = {{(REG_W-7){1'b0}}, force_q, mask, sn_req, ld_req, wrap_en, cnt_en, run_n};
      A_FQL: rdata = freq[REG_W-1:0];
      A_FQH: rdata = freq[CNT_W-1:REG_W];
      A_LDL: rdata = ld_val[REG_W-1:0];
      A_LDH: rdata = ld_val[CNT_W-1:REG_W];
      A_MTL: rdata = match_val[REG_W-1:0];
      A_MTH: rdata = match_val[CNT_W-1:REG_W];
      A_STS: rdata = {{(REG_W-2){1'b0}}, irq, raw};
      A_CPL: rdata = snap[REG_W-1:0];
      A_CPH: rdata = snap[CNT_W-1:REG_W];
      default: rdata = '0;
    endcase
  end

  assert_load_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && ld_req && !ld_stg) |=> ld_stg);
  assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && ld_stg) |=> (cnt_q == $past(ld_val)));
  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && sn_stg && !ld_stg) |=> (snap == $past(cnt_q)));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && !cnt_en && !ld_stg) |=> ($stable(cnt_q) && $stable(pre_q)));
  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && !wrap_en && at_top && !ld_stg) |=> (&cnt_q));
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && pend && !clr_wr) |=> pend);
  assert_softrst_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_n) |=> (cnt_q == '0 && pre_q == '0 && !pend && !ld_req && !sn_req));
endmodule

// File: tb/sec_rtc_test.sv
`timescale 1ns/1ps
module sec_rtc_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq;
  int vectors = 0, errors = 0;

  localparam logic [5:0] CTL = 6'h00, FQL = 6'h04, FQH = 6'h08, LDL = 6'h0C, LDH = 6'h10,
                         MTL = 6'h14, MTH = 6'h18, STS = 6'h1C, CPL = 6'h20, CPH = 6'h24;

  sec_rtc uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
               .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  function automatic logic [15:0] mkctl(input bit en, input bit wrap, input bit msk, input bit frc);
    return {9'b0, frc, msk, 2'b00, wrap, en, 1'b1};
  endfunction

  function automatic logic [31:0] advance(input logic [31:0] v, input int n, input bit wrap);
    for (int i = 0; i < n; i++) begin
      if (v == 32'hFFFF_FFFF) v = wrap ? 32'h0 : v;
      else v = v + 1;
    end
    return v;
  endfunction

  task automatic srst();
    wr(CTL, 16'h0000);
    wr(CTL, 16'h0001);
  endtask

  task automatic setf(input logic [31:0] f);
    wr(FQL, f[15:0]);
    wr(FQH, f[31:16]);
  endtask

  task automatic load32(input logic [31:0] v, input logic [15:0] base);
    wr(LDL, v[15:0]);
    wr(LDH, v[31:16]);
    wr(CTL, base | 16'h0008);
    repeat (2) @(negedge clk);
  endtask

  task automatic snap32(input logic [15:0] base, output logic [31:0] v);
    logic [15:0] lo, hi;
    wr(CTL, base | 16'h0010);
    repeat (2) @(negedge clk);
    rd(CPL, lo);
    rd(CPH, hi);
    v = {hi, lo};
  endtask

  task automatic run_for(input int n, input logic [15:0] base);
    wr(CTL, base | 16'h0002);
    repeat (n - 2) @(negedge clk);
    wr(CTL, base);
  endtask

  initial begin
    logic [15:0] d;
    logic [31:0] v, st, m;
    logic [15:0] base;
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd(CTL, d); check("R12 ctl", {16'h0, d}, 32'h1);
    rd(FQL, d); check("R12 freq lo", {16'h0, d}, 32'h8000);
    rd(FQH, d); check("R12 freq hi", {16'h0, d}, 32'h0);
    rd(STS, d); check("R12 status", {16'h0, d}, 32'h0);
    check("R12 irq", {31'h0, irq}, 32'h0);
    rd(CPL, d); check("R12 capture", {16'h0, d}, 32'h0);

    // R1 readback, clear bit reads 0, unmapped address
    wr(MTL, 16'hBEEF); wr(MTH, 16'hDEAD);
    rd(MTL, d); check("R1 match lo", {16'h0, d}, 32'hBEEF);
    rd(MTH, d); check("R1 match hi", {16'h0, d}, 32'hDEAD);
    wr(CTL, 16'h0085);
    rd(CTL, d); check("R1 clear reads 0", {16'h0, d}, 32'h0005);
    rd(6'h02, d); check("R1 unmapped", {16'h0, d}, 32'h0);

    // R3 request timing
    base = mkctl(0, 0, 0, 0);
    wr(CTL, base);
    wr(LDL, 16'h1234); wr(LDH, 16'h5678);
    wr(CTL, base | 16'h0008);
    peek(CTL, d); check("R3 req after write", {31'h0, d[3]}, 32'h1);
    @(negedge clk); peek(CTL, d); check("R3 req one edge later", {31'h0, d[3]}, 32'h1);
    @(negedge clk); peek(CTL, d); check("R3 req done", {31'h0, d[3]}, 32'h0);
    snap32(base, v); check("R3 loaded value", v, 32'h5678_1234);

    // R2 writing 0 does not cancel a pending request
    wr(LDL, 16'h0001); wr(LDH, 16'h0000);
    wr(CTL, base | 16'h0008);
    wr(CTL, base);
    @(negedge clk);
    snap32(base, v); check("R2 request not cancelled", v, 32'h1);

    // R4 combined load and snapshot, ignored writes
    wr(LDL, 16'hAAAA); wr(LDH, 16'h0F0F);
    wr(CTL, base | 16'h0018);
    peek(CTL, d); check("R4 snap req set", {31'h0, d[4]}, 32'h1);
    repeat (2) @(negedge clk);
    peek(CTL, d); check("R4 snap req done", {31'h0, d[4]}, 32'h0);
    rd(CPL, d); v[15:0] = d; rd(CPH, d); v[31:16] = d;
    check("R4 load then capture", v, 32'h0F0F_AAAA);
    wr(CPL, 16'hFFFF); wr(CPH, 16'hFFFF); wr(STS, 16'hFFFF);
    rd(CPL, d); check("R4 capture lo write ignored", {16'h0, d}, 32'hAAAA);
    rd(CPH, d); check("R4 capture hi write ignored", {16'h0, d}, 32'h0F0F);
    rd(STS, d); check("R4 status write ignored", {16'h0, d}, 32'h0);

    // R5 prescaler, frequency 0 acts as 1
    srst(); setf(32'd0); load32(32'd100, base); run_for(4, base);
    snap32(base, v); check("R5 freq zero", v, 32'd104);
    srst(); setf(32'd3); load32(32'd10, base); run_for(8, base);
    snap32(base, v); check("R5 freq three", v, 32'd12);
    // R6 hold while disabled
    repeat (12) @(negedge clk);
    snap32(base, v); check("R6 hold", v, 32'd12);
    run_for(2, base);
    snap32(base, v); check("R6 prescaler kept", v, 32'd13);

    // R7 wrap and saturate
    srst(); setf(32'd1); load32(32'hFFFF_FFFE, base); run_for(4, base);
    snap32(base, v); check("R7 saturate", v, 32'hFFFF_FFFF);
    base = mkctl(0, 1, 0, 0); wr(CTL, base);
    load32(32'hFFFF_FFFE, base); run_for(4, base);
    snap32(base, v); check("R7 wrap", v, 32'h0000_0002);

    // R8 / R9 alarm, mask, force
    base = mkctl(0, 0, 0, 0);
    srst(); wr(CTL, base); setf(32'd1);
    m = 32'h0001_2345;
    wr(MTL, m[15:0]); wr(MTH, m[31:16]);
    load32(m - 3, base); run_for(5, base);
    rd(STS, d); check("R8 alarm status", {16'h0, d}, 32'h3);
    check("R8 irq on match", {31'h0, irq}, 32'h1);
    wr(CTL, mkctl(0, 0, 1, 0));
    rd(STS, d); check("R9 masked status", {16'h0, d}, 32'h1);
    check("R8 irq masked", {31'h0, irq}, 32'h0);
    wr(CTL, mkctl(0, 0, 1, 0) | 16'h0080);
    rd(STS, d); check("R10 clear", {16'h0, d}, 32'h0);
    wr(CTL, mkctl(0, 0, 0, 1));
    rd(STS, d); check("R9 force status", {16'h0, d}, 32'h3);
    check("R9 force irq", {31'h0, irq}, 32'h1);
    wr(CTL, base);
    check("R9 force off", {31'h0, irq}, 32'h0);

    // R10 match wins over same-edge clear
    load32(m - 5, base);
    wr(CTL, base | 16'h0002);
    repeat (3) @(negedge clk);
    wr(CTL, base | 16'h0082);
    wr(CTL, base);
    rd(STS, d); check("R10 match beats clear", {16'h0, d}, 32'h3);

    // R11 soft reset clears state, keeps config
    wr(CTL, 16'h0000);
    @(negedge clk);
    wr(CTL, base);
    rd(STS, d); check("R11 status cleared", {16'h0, d}, 32'h0);
    rd(MTL, d); check("R11 match kept", {16'h0, d}, {16'h0, m[15:0]});
    rd(FQL, d); check("R11 freq kept", {16'h0, d}, 32'h1);
    snap32(base, v); check("R11 counter cleared", v, 32'h0);

    // random runs (R5, R7)
    wr(MTL, 16'h0000); wr(MTH, 16'h0000);
    for (int i = 0; i < 24; i++) begin
      int f, n;
      bit w;
      st = $urandom();
      if (i % 4 == 0) st = 32'hFFFF_FFF0 | ($urandom() & 32'hF);
      f = 1 + int'($urandom() % 6);
      n = 2 + int'($urandom() % 30);
      w = $urandom() % 2 == 1;
      base = mkctl(0, w, 0, 0);
      srst(); wr(CTL, base); setf(f);
      load32(st, base); run_for(n, base);
      snap32(base, v);
      check($sformatf("R5 R7 random run %0d", i), v, advance(st, n / f, w));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule